// File: doc/BRIEF.md
# Two-Level Interrupt Status Aggregator

This block gathers interrupt events for a storage controller that contains two independent functions. Each function records bus-side events in two SCSI status registers and DMA events in one DMA status register. Every status register has an enable mask of the same width. The enabled bits are reduced into two summary flags in a top-level register. That register also holds a write-one-to-clear on-the-fly flag raised by the sequencer, a software signal-process bit and two mailbox bytes.

A host reaches all registers through one register port. The port carries a function select, an address, a write strobe and a read strobe, and read data returns in the same cycle. While the sequencer runs, only the top-level register and the mailboxes respond. The blocks drive two active-low interrupt lines. Function A always uses line A. Function B uses line B, or shares line A when a strap is high during reset.

Top module: `intagg_top`

## Requirements
- R1: After reset every status, enable, mailbox and top-level field of both functions reads 0, and both interrupt lines are high.
- R2: When the strap is low during reset, function B drives only line B. When the strap is high during reset, function B drives line A and line B stays high.
- R3: A sequencer pulse sets the on-the-fly flag, which is bit 2 of the top-level register (address 0). Only a host write with bit 2 at one clears it, and a write with bit 2 at zero leaves it set.
- R4: While the on-the-fly flag of a function is set, host reads of that function's status registers return their contents and clear nothing.
- R5: Bit 1 of the top-level register is the SCSI summary. It is one exactly when a bit of either SCSI status register (address 3 or 4) is set while the matching bit of its enable register (address 6 or 7) is set.
- R6: Bit 0 of the top-level register is the DMA summary. It is one exactly when a bit of the DMA status register (address 5) is set while the matching bit of the DMA enable register (address 8) is set.
- R7: Status bits whose enable bit is clear are still recorded and read back, but they raise neither a summary bit nor an interrupt.
- R8: While the sequencer-running input is high, the top-level register and the mailboxes (addresses 1 and 2) remain readable and writable. Reads of addresses 3 to 8 return 0, writes to them are ignored, and reads clear nothing.
- R9: Bit 5 of the top-level register is a signal-process bit that the host writes and reads back.
- R10: A host read of a status register clears the bits it returns. An event that arrives in the same cycle as the read is kept.
- R11: An interrupt line is low while any function mapped to it has its on-the-fly flag or either summary bit set. A shared line stays low until both functions are quiet.
- R12: When the host and the sequencer write the same mailbox in the same cycle, the host value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the strap is sampled while it is low |
| strap_share | input | 1 | High during reset routes function B to line A |
| seq_running | input | 1 | Sequencer active; restricts host access |
| host_func | input | 1 | Function addressed by the host (0 = A, 1 = B) |
| host_addr | input | 4 | Register address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe; status reads clear |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data, valid in the cycle of host_rd |
| scsi0_evt | input | 2*SW | First SCSI event pulses, function f in slice f |
| scsi1_evt | input | 2*SW | Second SCSI event pulses |
| dma_evt | input | 2*DW | DMA event pulses |
| seq_intf | input | 2 | Sequencer on-the-fly pulse per function |
| seq_mb_we | input | 2 | Sequencer mailbox write per function |
| seq_mb_sel | input | 1 | Sequencer mailbox select (0 or 1) |
| seq_mb_wdata | input | 8 | Sequencer mailbox data |
| irq_a_n | output | 1 | Interrupt line A, active low |
| irq_b_n | output | 1 | Interrupt line B, active low |

## Verification
The assertions check several rules on every cycle. The on-the-fly flag persists until a write-one clear. No status bit is dropped by a read while that flag is set. Enables stay frozen while the sequencer runs. The host wins a mailbox write. Line B stays quiet when it is shared, and an on-the-fly flag always pulls its line low. Only the bench's scenarios can show that the summary bits reduce the enabled bits correctly, that read-clear keeps a same-cycle event, and that a shared line releases only after both functions are cleared. The bench sweeps every bit of every status register against its enable masks, and it repeats the routing checks with the strap at each value.

// File: rtl/intagg_pkg.sv
package intagg_pkg;
   localparam int ADDR_W = 4;
   localparam int DATA_W = 8;

   localparam logic [ADDR_W-1:0] RA_TOP  = 4'd0;
   localparam logic [ADDR_W-1:0] RA_MB0  = 4'd1;
   localparam logic [ADDR_W-1:0] RA_MB1  = 4'd2;
   localparam logic [ADDR_W-1:0] RA_SST0 = 4'd3;
   localparam logic [ADDR_W-1:0] RA_SST1 = 4'd4;
   localparam logic [ADDR_W-1:0] RA_DST  = 4'd5;
   localparam logic [ADDR_W-1:0] RA_SEN0 = 4'd6;
   localparam logic [ADDR_W-1:0] RA_SEN1 = 4'd7;
   localparam logic [ADDR_W-1:0] RA_DEN  = 4'd8;

   localparam int TB_DSUM = 0;
   localparam int TB_SSUM = 1;
   localparam int TB_INTF = 2;
   localparam int TB_SIGP = 5;
endpackage

// File: rtl/intagg_stat_bank.sv
module intagg_stat_bank #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic         en_wr,
   input  logic [W-1:0] en_wdata,
   input  logic         rd_clr,
   output logic [W-1:0] stat,
   output logic [W-1:0] en,
   output logic         hit
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat <= '0;
         en   <= '0;
      end else begin
         // a clearing read drops what it returned; new events survive
         stat <= rd_clr ? evt : (stat | evt);
         if (en_wr) en <= en_wdata;
      end
   end

   assign hit = |(stat & en);
endmodule

// File: rtl/intagg_func.sv
module intagg_func
   import intagg_pkg::*;
#(
   parameter int SW = 8,
   parameter int DW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              seq_running,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic [SW-1:0]     scsi0_evt,
   input  logic [SW-1:0]     scsi1_evt,
   input  logic [DW-1:0]     dma_evt,
   input  logic              seq_intf,
   input  logic              seq_mb_we,
   input  logic              seq_mb_sel,
   input  logic [DATA_W-1:0] seq_mb_wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              req,
   output logic              intf,
   output logic [SW-1:0]     sst0,
   output logic [SW-1:0]     sst1,
   output logic [DW-1:0]     dst,
   output logic [SW-1:0]     sen0,
   output logic [SW-1:0]     sen1,
   output logic [DW-1:0]     den,
   output logic [DATA_W-1:0] mb0,
   output logic [DATA_W-1:0] mb1
);
   logic top_zone, allowed, wr_ok, rd_ok, clr_ok;
   logic hit0, hit1, hitd, scsi_sum, sigp;

   assign top_zone = (host_addr == RA_TOP) || (host_addr == RA_MB0) ||
                     (host_addr == RA_MB1);
   assign allowed  = top_zone || !seq_running;
   assign wr_ok    = sel && host_wr && allowed;
   assign rd_ok    = sel && host_rd && allowed;
   assign clr_ok   = rd_ok && !intf;

   intagg_stat_bank #(.W(SW)) u_sst0 (
      .clk(clk), .rst_n(rst_n), .evt(scsi0_evt),
      .en_wr(wr_ok && host_addr == RA_SEN0), .en_wdata(host_wdata[SW-1:0]),
      .rd_clr(clr_ok && host_addr == RA_SST0),
      .stat(sst0), .en(sen0), .hit(hit0));

   intagg_stat_bank #(.W(SW)) u_sst1 (
      .clk(clk), .rst_n(rst_n), .evt(scsi1_evt),
      .en_wr(wr_ok && host_addr == RA_SEN1), .en_wdata(host_wdata[SW-1:0]),
      .rd_clr(clr_ok && host_addr == RA_SST1),
      .stat(sst1), .en(sen1), .hit(hit1));

   intagg_stat_bank #(.W(DW)) u_dst (
      .clk(clk), .rst_n(rst_n), .evt(dma_evt),
      .en_wr(wr_ok && host_addr == RA_DEN), .en_wdata(host_wdata[DW-1:0]),
      .rd_clr(clr_ok && host_addr == RA_DST),
      .stat(dst), .en(den), .hit(hitd));

   assign scsi_sum = hit0 || hit1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         intf <= 1'b0;
         sigp <= 1'b0;
         mb0  <= '0;
         mb1  <= '0;
      end else begin
         if (seq_intf)
            intf <= 1'b1;
         else if (wr_ok && host_addr == RA_TOP && host_wdata[TB_INTF])
            intf <= 1'b0;
         if (wr_ok && host_addr == RA_TOP)
            sigp <= host_wdata[TB_SIGP];
         // host first, sequencer second
         if (wr_ok && host_addr == RA_MB0)
            mb0 <= host_wdata;
         else if (seq_mb_we && !seq_mb_sel)
            mb0 <= seq_mb_wdata;
         if (wr_ok && host_addr == RA_MB1)
            mb1 <= host_wdata;
         else if (seq_mb_we && seq_mb_sel)
            mb1 <= seq_mb_wdata;
      end
   end

   always_comb begin
      rdata = '0;
      if (rd_ok) begin
         case (host_addr)
            RA_TOP: begin
               rdata[TB_DSUM] = hitd;
               rdata[TB_SSUM] = scsi_sum;
               rdata[TB_INTF] = intf;
               rdata[TB_SIGP] = sigp;
            end
            RA_MB0:  rdata = mb0;
            RA_MB1:  rdata = mb1;
            RA_SST0: rdata[SW-1:0] = sst0;
            RA_SST1: rdata[SW-1:0] = sst1;
            RA_DST:  rdata[DW-1:0] = dst;
            RA_SEN0: rdata[SW-1:0] = sen0;
            RA_SEN1: rdata[SW-1:0] = sen1;
            RA_DEN:  rdata[DW-1:0] = den;
            default: rdata = '0;
         endcase
      end
   end

   assign req = intf || scsi_sum || hitd;
endmodule

// File: rtl/intagg_irq_route.sv
module intagg_irq_route #(
   parameter bit STRAP_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       strap,
   input  logic [1:0] req,
   output logic       route_shared,
   output logic       irq_a_n,
   output logic       irq_b_n
);
   generate
      if (STRAP_EN) begin : g_strap
         logic share_q;
         always_ff @(posedge clk) begin
            if (!rst_n) share_q <= strap;
         end
         assign route_shared = share_q;
      end else begin : g_fixed
         logic unused_strap;
         assign unused_strap = strap ^ clk;
         assign route_shared = 1'b0;
      end
   endgenerate

   assign irq_a_n = !(req[0] || (route_shared && req[1]));
   assign irq_b_n = !(!route_shared && req[1]);
endmodule

// File: rtl/intagg_top.sv
module intagg_top
   import intagg_pkg::*;
#(
   parameter int SW       = 8,
   parameter int DW       = 8,
   parameter bit STRAP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_share,
   input  logic              seq_running,
   input  logic              host_func,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic [2*SW-1:0]   scsi0_evt,
   input  logic [2*SW-1:0]   scsi1_evt,
   input  logic [2*DW-1:0]   dma_evt,
   input  logic [1:0]        seq_intf,
   input  logic [1:0]        seq_mb_we,
   input  logic              seq_mb_sel,
   input  logic [DATA_W-1:0] seq_mb_wdata,
   output logic              irq_a_n,
   output logic              irq_b_n
);
   localparam int NF = 2;

   if (SW < 1 || SW > DATA_W) begin : g_bad_sw
      $error("intagg_top: SW must lie in 1..DATA_W");
   end
   if (DW < 1 || DW > DATA_W) begin : g_bad_dw
      $error("intagg_top: DW must lie in 1..DATA_W");
   end

   logic [NF-1:0][DATA_W-1:0] rd_f;
   logic [NF-1:0]             req;
   logic [NF-1:0]             intf;
   logic [NF-1:0][SW-1:0]     sst0, sst1, sen0, sen1;
   logic [NF-1:0][DW-1:0]     dst, den;
   logic [NF-1:0][DATA_W-1:0] mb0, mb1;
   logic                      route_shared;

   for (genvar f = 0; f < NF; f++) begin : g_fn
      intagg_func #(.SW(SW), .DW(DW)) u_fn (
         .clk(clk), .rst_n(rst_n),
         .sel(host_func == f[0]),
         .seq_running(seq_running),
         .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
         .host_wdata(host_wdata),
         .scsi0_evt(scsi0_evt[f*SW +: SW]),
         .scsi1_evt(scsi1_evt[f*SW +: SW]),
         .dma_evt(dma_evt[f*DW +: DW]),
         .seq_intf(seq_intf[f]),
         .seq_mb_we(seq_mb_we[f]), .seq_mb_sel(seq_mb_sel),
         .seq_mb_wdata(seq_mb_wdata),
         .rdata(rd_f[f]), .req(req[f]), .intf(intf[f]),
         .sst0(sst0[f]), .sst1(sst1[f]), .dst(dst[f]),
         .sen0(sen0[f]), .sen1(sen1[f]), .den(den[f]),
         .mb0(mb0[f]), .mb1(mb1[f]));
   end

   assign host_rdata = rd_f[0] | rd_f[1];

   intagg_irq_route #(.STRAP_EN(STRAP_EN)) u_route (
      .clk(clk), .rst_n(rst_n), .strap(strap_share), .req(req),
      .route_shared(route_shared), .irq_a_n(irq_a_n), .irq_b_n(irq_b_n));
endmodule

// File: rtl/intagg_chk.sv
module intagg_chk
   import intagg_pkg::*;
#(
   parameter int SW = 8,
   parameter int DW = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  seq_running,
   input logic                  host_func,
   input logic [ADDR_W-1:0]     host_addr,
   input logic                  host_wr,
   input logic                  host_rd,
   input logic [DATA_W-1:0]     host_wdata,
   input logic                  irq_a_n,
   input logic                  irq_b_n,
   input logic                  route_shared,
   input logic [1:0]            intf,
   input logic [1:0][DW-1:0]    dst,
   input logic [1:0][SW-1:0]    sen0,
   input logic [1:0][DW-1:0]    den,
   input logic [1:0][DATA_W-1:0] mb0
);
   for (genvar f = 0; f < 2; f++) begin : g_f
      p_intf_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (intf[f] && !(host_wr && host_func == f[0] && host_addr == RA_TOP
                       && host_wdata[TB_INTF])) |=> intf[f]);

      p_noclear_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (intf[f] && host_rd && host_func == f[0] && host_addr == RA_DST)
         |=> ((dst[f] & $past(dst[f])) == $past(dst[f])));

      p_run_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (seq_running && host_wr && host_func == f[0])
         |=> ($stable(sen0[f]) && $stable(den[f])));

      p_mb_host_r12: assert property (@(posedge clk) disable iff (!rst_n)
         (host_wr && host_func == f[0] && host_addr == RA_MB0)
         |=> (mb0[f] == $past(host_wdata)));
   end

   p_b_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      route_shared |-> irq_b_n);

   p_f1_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (intf[1] && !route_shared) |-> !irq_b_n);

   p_f0_line_r11: assert property (@(posedge clk) disable iff (!rst_n)
      intf[0] |-> !irq_a_n);
endmodule

bind intagg_top intagg_chk #(.SW(SW), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .seq_running(seq_running),
   .host_func(host_func), .host_addr(host_addr), .host_wr(host_wr),
   .host_rd(host_rd), .host_wdata(host_wdata),
   .irq_a_n(irq_a_n), .irq_b_n(irq_b_n), .route_shared(route_shared),
   .intf(intf), .dst(dst), .sen0(sen0), .den(den), .mb0(mb0));

// File: tb/tb_intagg_top.sv
`timescale 1ns/1ps
module tb_intagg_top;
   localparam int SW = 8;
   localparam int DW = 8;

   logic clk = 0, rst_n = 0, strap_share = 0, seq_running = 0;
   logic host_func = 0, host_wr = 0, host_rd = 0;
   logic [3:0] host_addr = 0;
   logic [7:0] host_wdata = 0, host_rdata;
   logic [2*SW-1:0] scsi0_evt = 0, scsi1_evt = 0;
   logic [2*DW-1:0] dma_evt = 0;
   logic [1:0] seq_intf = 0, seq_mb_we = 0;
   logic seq_mb_sel = 0;
   logic [7:0] seq_mb_wdata = 0;
   logic irq_a_n, irq_b_n;

   int checks = 0, fails = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   intagg_top #(.SW(SW), .DW(DW)) dut (.*);

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic s);
      @(negedge clk); rst_n = 0; strap_share = s;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
   endtask

   task automatic rd(input int f, input int a, output logic [7:0] d);
      @(negedge clk); host_func = f[0]; host_addr = a[3:0]; host_rd = 1;
      #1 d = host_rdata;
      @(posedge clk); #1 host_rd = 0;
   endtask

   task automatic wr(input int f, input int a, input logic [7:0] v);
      @(negedge clk); host_func = f[0]; host_addr = a[3:0];
      host_wdata = v; host_wr = 1;
      @(posedge clk); #1 host_wr = 0;
   endtask

   task automatic pulse(input int f, input int r, input logic [7:0] m);
      @(negedge clk);
      case (r)
         0: scsi0_evt[f*SW +: SW] = m;
         1: scsi1_evt[f*SW +: SW] = m;
         default: dma_evt[f*DW +: DW] = m;
      endcase
      @(posedge clk); #1 scsi0_evt = 0; scsi1_evt = 0; dma_evt = 0;
   endtask

   task automatic intf_pulse(input int f);
      @(negedge clk); seq_intf[f] = 1;
      @(posedge clk); #1 seq_intf = 0;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      logic [7:0] en;
      do_reset(0);
      // R1 reset state
      chk("R1 irq_a", irq_a_n, 1);
      chk("R1 irq_b", irq_b_n, 1);
      for (int f = 0; f < 2; f++)
         for (int a = 0; a < 9; a++) begin
            rd(f, a, d); chk("R1 reg", d, 0);
         end

      // R5/R6/R7/R10/R11/R2: sweep every bit against enable patterns
      for (int f = 0; f < 2; f++)
         for (int r = 0; r < 3; r++)
            for (int b = 0; b < 8; b++)
               for (int e = 0; e < 3; e++) begin
                  en = (e == 0) ? 8'h00 : (e == 1) ? 8'(1 << b) : ~8'(1 << b);
                  wr(f, 6 + r, en);
                  pulse(f, r, 8'(1 << b));
                  chk("R11 line A", irq_a_n, !(f == 0 && en[b]));
                  chk("R2 line B", irq_b_n, !(f == 1 && en[b]));
                  rd(f, 0, d);
                  chk(r == 2 ? "R6 dsum" : "R5 ssum", d,
                      en[b] ? (r == 2 ? 1 : 2) : 0);
                  rd(f, 3 + r, d); chk("R7 recorded", d, 1 << b);
                  rd(f, 3 + r, d); chk("R10 cleared", d, 0);
                  chk("R11 released", irq_a_n & irq_b_n, 1);
               end

      // R10 same-cycle event survives read-clear
      wr(0, 8, 8'hFF);
      pulse(0, 2, 8'h02);
      @(negedge clk); host_func = 0; host_addr = 5; host_rd = 1;
      dma_evt[7:0] = 8'h08;
      #1 d = host_rdata;
      @(posedge clk); #1 host_rd = 0; dma_evt = 0;
      chk("R10 first read", d, 8'h02);
      rd(0, 5, d); chk("R10 kept event", d, 8'h08);

      // R3/R4 on-the-fly flag
      intf_pulse(0);
      pulse(0, 2, 8'h01);
      rd(0, 0, d); chk("R3 flag set", d, 8'h05);
      rd(0, 5, d); chk("R4 read", d, 8'h01);
      rd(0, 5, d); chk("R4 not cleared", d, 8'h01);
      wr(0, 0, 8'h00);
      rd(0, 0, d); chk("R3 write0 keeps", d[2], 1);
      chk("R11 flag irq", irq_a_n, 0);
      wr(0, 0, 8'h04);
      rd(0, 0, d); chk("R3 w1c", d[2], 0);
      rd(0, 5, d); chk("R4 clear after", d, 8'h01);
      rd(0, 5, d); chk("R10 now cleared", d, 8'h00);

      // R9 signal-process bit
      wr(1, 0, 8'h20);
      rd(1, 0, d); chk("R9 set", d, 8'h20);
      wr(1, 0, 8'h00);
      rd(1, 0, d); chk("R9 clear", d, 8'h00);

      // R8 running lock
      wr(1, 6, 8'h0F);
      pulse(1, 0, 8'h03);
      @(negedge clk); seq_running = 1;
      rd(1, 6, d); chk("R8 enable hidden", d, 0);
      wr(1, 6, 8'hF0);
      rd(1, 3, d); chk("R8 status hidden", d, 0);
      rd(1, 0, d); chk("R8 top readable", d, 8'h02);
      wr(1, 1, 8'h5A);
      rd(1, 1, d); chk("R8 mailbox rw", d, 8'h5A);
      @(negedge clk); seq_running = 0;
      rd(1, 6, d); chk("R8 write ignored", d, 8'h0F);
      rd(1, 3, d); chk("R8 no clear", d, 8'h03);

      // R12 mailbox collision
      @(negedge clk); host_func = 0; host_addr = 1; host_wdata = 8'hA5;
      host_wr = 1; seq_mb_we = 2'b01; seq_mb_sel = 0; seq_mb_wdata = 8'h3C;
      @(posedge clk); #1 host_wr = 0; seq_mb_we = 0;
      rd(0, 1, d); chk("R12 host wins", d, 8'hA5);
      @(negedge clk); seq_mb_we = 2'b01; seq_mb_sel = 1; seq_mb_wdata = 8'hC3;
      @(posedge clk); #1 seq_mb_we = 0;
      rd(0, 2, d); chk("R12 seq write", d, 8'hC3);

      // R2/R11 strap high: shared line A
      do_reset(1);
      chk("R1 irq after reset", irq_a_n & irq_b_n, 1);
      wr(1, 8, 8'h01);
      pulse(1, 2, 8'h01);
      chk("R2 B on A", irq_a_n, 0);
      chk("R2 B quiet", irq_b_n, 1);
      intf_pulse(0);
      rd(1, 5, d);
      chk("R11 shared held", irq_a_n, 0);
      wr(0, 0, 8'h04);
      chk("R11 shared released", irq_a_n, 1);

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule